// File: doc/BRIEF.md
# Piecewise-Linear Function Evaluator

This block evaluates a nonlinear function, such as a natural logarithm, over a fixed interval. It does so with straight-line segments. A signed Q4.12 sample is compared against a set of strictly increasing breakpoints, and every comparison is made at the same time. The comparison results form a thermometer code. An edge detector turns the 0-to-1 transition in that code into a one-hot vector, and an encoder turns the one-hot vector into a segment number.

The segment number picks a slope and an intercept from constant tables. The result is slope times sample plus intercept, rounded and clamped back to Q4.12. Breakpoints and coefficients are parameters packed into flat vectors, with entry k at bits [k*W +: W]. The block accepts one sample per clock cycle. Each result leaves exactly three cycles after its sample entered, together with a valid flag.

Top module: `pwl_eval`

## Requirements
- R1: With breakpoints b0 < b1 < ... < b9, a sample x below b0 uses segment 0. A sample with b(k-1) <= x < b(k) uses segment k. A sample at or above b9 uses segment 10.
- R2: A sample exactly equal to a breakpoint b(k) is placed in the segment above it (segment k+1).
- R3: The result equals floor((slope*x + intercept*2^12 + 2^11) / 2^12). Here x, slope, intercept and result are all two's-complement Q4.12, and the product is kept at full precision. Ties therefore round toward plus infinity.
- R4: A rounded value above 32767 produces 32767 (0x7FFF). A rounded value below -32768 produces -32768 (0x8000).
- R5: `res_vld` equals `smp_vld` delayed by exactly three clock cycles. A new sample may enter every cycle, and cycles without a sample produce cycles without a result.
- R6: While `rst` is high, `res_vld` and `res_y` are 0 one cycle after any rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | A sample is present on `smp_x` this cycle |
| smp_x | input | 16 | Signed Q4.12 input sample |
| res_vld | output | 1 | `res_y` holds a result this cycle |
| res_y | output | 16 | Signed Q4.12 result, rounded and saturated |

## Verification
The bench drives each breakpoint exactly and one LSB below it. A design that compared with less-or-equal, or that decoded the thermometer edge one position off, would pick the wrong segment's coefficients at those points. A full sweep of all 65536 input codes reaches both full-scale extremes and every rounding tie. A design that truncated instead of rounding, or that wrapped instead of clamping, would therefore be off by one LSB or flip sign. The sweep skips a sample every seventh cycle. A pipeline with the wrong depth, or a valid flag that ignored gaps, would then pair results with the wrong slots.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    localparam int XW_DEF   = 16;
    localparam int CW_DEF   = 16;
    localparam int FRAC_DEF = 12;
    localparam int NBRK_DEF = 10;

    // Default breakpoints: evenly spaced, strictly increasing, one Q4.12 unit apart
    function automatic logic [NBRK_DEF*XW_DEF-1:0] dflt_brk();
        logic [NBRK_DEF*XW_DEF-1:0] r;
        r = '0;
        for (int k = 0; k < NBRK_DEF; k++) begin
            r[k*XW_DEF +: XW_DEF] = XW_DEF'(-18432 + 4096 * k);
        end
        return r;
    endfunction

    // Default slopes: decreasing, a concave curve in the manner of a logarithm
    function automatic logic [(NBRK_DEF+1)*CW_DEF-1:0] dflt_slope();
        logic [(NBRK_DEF+1)*CW_DEF-1:0] r;
        r = '0;
        for (int s = 0; s <= NBRK_DEF; s++) begin
            r[s*CW_DEF +: CW_DEF] = CW_DEF'(16384 - 1400 * s);
        end
        return r;
    endfunction

    // Default intercepts
    function automatic logic [(NBRK_DEF+1)*CW_DEF-1:0] dflt_icpt();
        logic [(NBRK_DEF+1)*CW_DEF-1:0] r;
        r = '0;
        for (int s = 0; s <= NBRK_DEF; s++) begin
            r[s*CW_DEF +: CW_DEF] = CW_DEF'(-24576 + 2800 * s);
        end
        return r;
    endfunction

endpackage

// File: rtl/pwl_cmp_bank.sv
// One signed less-than comparator per breakpoint, all fed the same sample.
// lt[NBRK] is tied high so that the edge is always found.
module pwl_cmp_bank #(
    parameter int                   XW       = 16,
    parameter int                   NBRK     = 10,
    parameter logic [NBRK*XW-1:0]   BRK_FLAT = '0
) (
    input  logic signed [XW-1:0] x,
    output logic [NBRK:0]        lt
);
    for (genvar k = 0; k < NBRK; k++) begin : g_cmp
        localparam logic signed [XW-1:0] BK = BRK_FLAT[k*XW +: XW];
        assign lt[k] = (x < BK);
    end
    assign lt[NBRK] = 1'b1;
endmodule

// File: rtl/pwl_seg_encoder.sv
// Finds the 0->1 edge of a thermometer code and encodes its position.
module pwl_seg_encoder #(
    parameter int NSEG = 11,
    parameter int IW   = 4
) (
    input  logic [NSEG-1:0] therm,
    output logic [NSEG-1:0] edge_oh,
    output logic [IW-1:0]   idx
);
    assign edge_oh[0] = therm[0];
    for (genvar k = 1; k < NSEG; k++) begin : g_edge
        assign edge_oh[k] = therm[k] & ~therm[k-1];
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < NSEG; k++) begin
            if (edge_oh[k]) idx = idx | IW'(k);
        end
    end
endmodule

// File: rtl/pwl_round_sat.sv
// Adds the aligned intercept to the full product, rounds half up, clamps.
module pwl_round_sat #(
    parameter int XW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int PW   = XW + CW
) (
    input  logic signed [PW-1:0] prod,
    input  logic signed [CW-1:0] icpt,
    output logic signed [XW-1:0] y
);
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] YMAX = (SW'(1) <<< (XW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] YMIN = -(SW'(1) <<< (XW - 1));
    localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC - 1);

    logic signed [SW-1:0] sum_w;
    logic signed [SW-1:0] rnd_w;
    logic signed [SW-1:0] shf_w;

    always_comb begin
        sum_w = SW'(prod) + (SW'(icpt) <<< FRAC);
        rnd_w = sum_w + HALF;
        shf_w = rnd_w >>> FRAC;
        if (shf_w > YMAX) begin
            y = YMAX[XW-1:0];
        end else if (shf_w < YMIN) begin
            y = YMIN[XW-1:0];
        end else begin
            y = shf_w[XW-1:0];
        end
    end
endmodule

// File: rtl/pwl_eval.sv
module pwl_eval #(
    parameter int XW   = pwl_pkg::XW_DEF,
    parameter int CW   = pwl_pkg::CW_DEF,
    parameter int FRAC = pwl_pkg::FRAC_DEF,
    parameter int NBRK = pwl_pkg::NBRK_DEF,
    parameter logic [NBRK*XW-1:0]     BRK_FLAT   = pwl_pkg::dflt_brk(),
    parameter logic [(NBRK+1)*CW-1:0] SLOPE_FLAT = pwl_pkg::dflt_slope(),
    parameter logic [(NBRK+1)*CW-1:0] ICPT_FLAT  = pwl_pkg::dflt_icpt()
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_vld,
    input  logic [XW-1:0] smp_x,
    output logic          res_vld,
    output logic [XW-1:0] res_y
);
    localparam int NSEG = NBRK + 1;
    localparam int IW   = $clog2(NSEG);
    localparam int PW   = XW + CW;

    typedef struct packed {
        logic                 s1_vld;
        logic signed [XW-1:0] s1_x;
        logic [IW-1:0]        s1_idx;
        logic                 s2_vld;
        logic signed [PW-1:0] s2_prod;
        logic signed [CW-1:0] s2_icpt;
        logic                 o_vld;
        logic signed [XW-1:0] o_y;
    } pipe_t;

    pipe_t q, d;

    logic [NSEG-1:0]      therm;
    logic [NSEG-1:0]      seg_oh;
    logic [IW-1:0]        seg_idx;
    logic signed [CW-1:0] slope_sel;
    logic signed [CW-1:0] icpt_sel;
    logic signed [XW-1:0] rs_y;

    // Stage 1: parallel compare and edge encode
    pwl_cmp_bank #(
        .XW(XW), .NBRK(NBRK), .BRK_FLAT(BRK_FLAT)
    ) u_cmp (
        .x  (smp_x),
        .lt (therm)
    );

    pwl_seg_encoder #(
        .NSEG(NSEG), .IW(IW)
    ) u_enc (
        .therm   (therm),
        .edge_oh (seg_oh),
        .idx     (seg_idx)
    );

    // Stage 3 arithmetic
    pwl_round_sat #(
        .XW(XW), .CW(CW), .FRAC(FRAC), .PW(PW)
    ) u_rs (
        .prod (q.s2_prod),
        .icpt (q.s2_icpt),
        .y    (rs_y)
    );

    // Stage 2 coefficient lookup
    always_comb begin
        slope_sel = SLOPE_FLAT[int'(q.s1_idx)*CW +: CW];
        icpt_sel  = ICPT_FLAT[int'(q.s1_idx)*CW +: CW];
    end

    always_comb begin
        d = q;
        d.s1_vld  = smp_vld;
        d.s1_x    = smp_x;
        d.s1_idx  = seg_idx;
        d.s2_vld  = q.s1_vld;
        d.s2_prod = q.s1_x * slope_sel;
        d.s2_icpt = icpt_sel;
        d.o_vld   = q.s2_vld;
        d.o_y     = rs_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign res_vld = q.o_vld;
    assign res_y   = q.o_y;
endmodule

// File: rtl/pwl_eval_chk.sv
module pwl_eval_chk #(
    parameter int XW   = 16,
    parameter int CW   = 16,
    parameter int FRAC = 12,
    parameter int NBRK = 10,
    parameter int IW   = 4,
    parameter int PW   = 32,
    parameter logic [NBRK*XW-1:0] BRK_FLAT = '0
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_vld,
    input logic                 res_vld,
    input logic [XW-1:0]        res_y,
    input logic [NBRK:0]        seg_oh,
    input logic signed [XW-1:0] s1_x,
    input logic [IW-1:0]        s1_idx,
    input logic                 s2_vld,
    input logic signed [PW-1:0] s2_prod,
    input logic signed [CW-1:0] s2_icpt
);
    localparam int SW = PW + 2;
    localparam logic signed [SW-1:0] LIM_HI = (SW'(1) <<< (XW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] LIM_LO = -(SW'(1) <<< (XW - 1));

    logic [1:0] since_rst;
    logic       rst_seen;
    logic       lo_ok, hi_ok;
    logic       over_hi, under_lo;
    logic signed [SW-1:0] wide;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    always_comb begin
        lo_ok = 1'b1;
        hi_ok = 1'b1;
        if (s1_idx != '0) begin
            lo_ok = (s1_x >= $signed(BRK_FLAT[(int'(s1_idx) - 1)*XW +: XW]));
        end
        if (int'(s1_idx) < NBRK) begin
            hi_ok = (s1_x < $signed(BRK_FLAT[int'(s1_idx)*XW +: XW]));
        end
        wide     = (SW'(s2_prod) + (SW'(s2_icpt) <<< FRAC) + (SW'(1) <<< (FRAC - 1))) >>> FRAC;
        over_hi  = wide > LIM_HI;
        under_lo = wide < LIM_LO;
    end

    // R1: exactly one edge in the thermometer code
    p_one_edge_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(seg_oh) == 1);

    // R1: registered sample is not below its segment's lower breakpoint
    p_seg_lower_r1: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0) |-> lo_ok);

    // R2: registered sample is strictly below its segment's upper breakpoint
    p_seg_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst != 2'd0) |-> hi_ok);

    // R4: clamp high
    p_sat_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && over_hi) |=> (res_y == LIM_HI[XW-1:0]));

    // R4: clamp low
    p_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (s2_vld && under_lo) |=> (res_y == LIM_LO[XW-1:0]));

    // R5: fixed three-cycle valid latency
    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd3) |-> (res_vld == $past(smp_vld, 3)));

    // R6: outputs cleared after a reset edge
    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_clear_r6: assert (!res_vld && res_y == '0);
        end
    end
endmodule

bind pwl_eval pwl_eval_chk #(
    .XW(XW), .CW(CW), .FRAC(FRAC), .NBRK(NBRK), .IW(IW), .PW(PW), .BRK_FLAT(BRK_FLAT)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_vld (smp_vld),
    .res_vld (res_vld),
    .res_y   (res_y),
    .seg_oh  (seg_oh),
    .s1_x    (q.s1_x),
    .s1_idx  (q.s1_idx),
    .s2_vld  (q.s2_vld),
    .s2_prod (q.s2_prod),
    .s2_icpt (q.s2_icpt)
);

// File: tb/sim_pwl_eval.sv
`timescale 1ns/1ps
module sim_pwl_eval;

    localparam int NB = 10;
    localparam int W  = 16;

    function automatic int b_brk(int k);
        return -20000 + 4000 * k;
    endfunction

    function automatic int b_slope(int s);
        if (s == 0 || s == NB) return 7500;
        return (s - 5) * 1500;
    endfunction

    function automatic int b_icpt(int s);
        return s * 3000 - 15000;
    endfunction

    function automatic logic [NB*W-1:0] mk_brk();
        logic [NB*W-1:0] r;
        r = '0;
        for (int k = 0; k < NB; k++) r[k*W +: W] = W'(b_brk(k));
        return r;
    endfunction

    function automatic logic [(NB+1)*W-1:0] mk_slope();
        logic [(NB+1)*W-1:0] r;
        r = '0;
        for (int s = 0; s <= NB; s++) r[s*W +: W] = W'(b_slope(s));
        return r;
    endfunction

    function automatic logic [(NB+1)*W-1:0] mk_icpt();
        logic [(NB+1)*W-1:0] r;
        r = '0;
        for (int s = 0; s <= NB; s++) r[s*W +: W] = W'(b_icpt(s));
        return r;
    endfunction

    // Reference: linear scan over breakpoints, then exact integer arithmetic
    function automatic int ref_y(int x);
        int     seg;
        longint full;
        longint r;
        seg = 0;
        for (int k = 0; k < NB; k++) begin
            if (x >= b_brk(k)) seg = k + 1;
        end
        full = longint'(x) * longint'(b_slope(seg)) + (longint'(b_icpt(seg)) <<< 12);
        r = (full + 2048) >>> 12;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         smp_vld = 1'b0;
    logic [W-1:0] smp_x = '0;
    logic         res_vld;
    logic [W-1:0] res_y;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    bit    p_v[3];
    int    p_y[3];
    string p_tag[3];

    always #10 clk = ~clk;

    pwl_eval #(
        .XW(W), .CW(W), .FRAC(12), .NBRK(NB),
        .BRK_FLAT(mk_brk()), .SLOPE_FLAT(mk_slope()), .ICPT_FLAT(mk_icpt())
    ) u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_x(smp_x),
        .res_vld(res_vld), .res_y(res_y)
    );

    task automatic check_out();
        checks++;
        if (res_vld !== p_v[2]) begin
            errors++;
            $display("FAIL R5 valid: actual %0b expected %0b", res_vld, p_v[2]);
        end
        if (p_v[2]) begin
            checks++;
            if ($signed(res_y) !== W'(p_y[2])) begin
                errors++;
                $display("FAIL %s data: actual %0d expected %0d", p_tag[2], $signed(res_y), p_y[2]);
            end
        end
    endtask

    // One cycle: check the result due now, then drive a new sample
    task automatic cyc(bit v, int x, string tag);
        @(negedge clk);
        check_out();
        p_v[2] = p_v[1]; p_y[2] = p_y[1]; p_tag[2] = p_tag[1];
        p_v[1] = p_v[0]; p_y[1] = p_y[0]; p_tag[1] = p_tag[0];
        p_v[0] = v;
        p_y[0] = ref_y(x);
        p_tag[0] = tag;
        smp_vld = v;
        smp_x   = W'(x);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin p_v[i] = 0; p_y[i] = 0; p_tag[i] = ""; end
        smp_vld = 1'b1;
        smp_x   = 16'h1234;
        repeat (4) @(negedge clk);
        // R6: reset clears outputs even with a sample presented
        checks++;
        if (res_vld !== 1'b0 || res_y !== '0) begin
            errors++;
            $display("FAIL R6 reset: actual %0b/%0d expected 0/0", res_vld, res_y);
        end
        smp_vld = 1'b0;
        @(negedge clk);
        rst = 1'b0;

        // R2: each breakpoint exactly (belongs to the upper segment), R1: one LSB below
        for (int k = 0; k < NB; k++) begin
            cyc(1'b1, b_brk(k), "R2");
            cyc(1'b1, b_brk(k) - 1, "R1");
        end
        // R4: extremes, back to back
        cyc(1'b1, -32768, "R4");
        cyc(1'b1, 32767, "R4");
        cyc(1'b1, -32767, "R4");
        cyc(1'b1, 32766, "R4");
        // R3/R5: full sweep with periodic gaps
        for (int x = -32768; x <= 32767; x++) begin
            cyc((((x + 32768) % 7) != 3), x, "R3");
        end
        for (int i = 0; i < 4; i++) cyc(1'b0, 0, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule